// File: doc/BRIEF.md
# Frame Slip Buffer

The block carries a byte stream between two clock domains. On the line side, bytes arrive on `wr_clk` and are placed in a circular store that holds two frames of 24 byte slots each, so 48 entries. On the system side, bytes leave on `rd_clk`. The two sides run free of each other. The write index is Gray-coded and passes through a two-flop synchroniser into the read domain. There the distance between the write and read indices is computed modulo the depth. When one side runs ahead of the other, the distance reaches an end of its range and the read index jumps by a whole frame. This is a controlled slip: a frame is either played twice or skipped. A one-cycle pulse on `slip` marks each jump.

Software-style control arrives on `align_req`, which is synchronised into the read domain. Only a rising edge of that input can act. If the synchronised distance is below half a frame (12 slots) at that edge, the read index is moved to sit exactly 12 slots behind the synchronised write index. Bytes near the jump are not preserved. If the distance is already 12 or more, nothing happens. While the input stays high it does nothing more. It must go low and then high again before it can act a second time. `too_close` shows whether the distance is currently below 12.

Both stream ports use valid/ready handshakes, with these back-pressure rules:
- The input side never pushes back. Once out of reset, `in_ready` stays high, and overruns are absorbed by slips.
- The output side always offers a byte. Once out of reset, `out_valid` stays high.
- Lowering `out_ready` holds the read index where it is.

Top module: `frame_slip_buffer`

## Requirements
- R1: After reset the read index is 0 and the write index is 12. `too_close` is 0 and `slip` is 0. The first 12 bytes read are 0x00, because the store is cleared by reset.
- R2: Without slips or realignment, every byte accepted on `in_valid && in_ready` at a `wr_clk` edge is delivered once, in order, on `out_valid && out_ready` at `rd_clk` edges. While `out_ready` is low the read index does not move.
- R3: `too_close` is 1 exactly when the synchronised distance (write index minus read index, modulo 48) is below 12.
- R4: On a rising edge of the synchronised `align_req`, if the distance is below 12, the read index becomes the synchronised write index minus 12. The next 12 bytes read are the 12 most recently written.
- R5: On a rising edge of `align_req`, if the distance is 12 or more (including exactly 12), the read index and the delivered data are unchanged.
- R6: While `align_req` stays high, no further realignment happens. Taking it to 0 and back to 1 produces a new realignment.
- R7: A read taken while the distance is 0 moves the read index back by 24 instead of forward. The next 24 bytes read repeat the last 24 written.
- R8: A read taken while the distance is 47 delivers the current byte and then advances the read index by 25, so the following 24 bytes are dropped.
- R9: Once out of reset, `in_ready` and `out_valid` stay high.
- R10: `slip` is high for exactly one `rd_clk` cycle after each R7 or R8 event, and never for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Line-side clock |
| rd_clk | input | 1 | System-side clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input accepted (high after reset) |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte present (high after reset) |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Output byte at the read index |
| align_req | input | 1 | Realign control, acts on a rising edge |
| too_close | output | 1 | Synchronised distance below half a frame |
| slip | output | 1 | One-cycle pulse on a frame slip |

## Verification
The hardest states to reach from the ports are the two distance extremes, 0 and 47, together with an exactly known distance at the moment `align_req` rises. Free-running streams only give an approximate distance, because the synchroniser lags. The bench therefore stops both streams and waits for the synchroniser to settle. It then walks the distance to a chosen value with counted writes or reads: 7, 8, exactly 12, exactly 0, and 47. After each slip or realignment, it rebuilds the expected queue from its own history of written bytes.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  // What the read index does at the next rd_clk edge.
  typedef enum logic [2:0] {
    RS_HOLD,
    RS_NEXT,
    RS_REPEAT,
    RS_DROP,
    RS_ALIGN
  } rd_step_e;
endpackage

// File: rtl/fsb_wr_ptr.sv
module fsb_wr_ptr #(
  parameter int DEPTH = 48,
  parameter int START = 12,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] addr,
  output logic [PW-1:0] gray
);
  // Codes run from OFF to OFF+DEPTH-1; for an even depth the wrap changes one bit.
  localparam int OFF = ((1 << PW) - DEPTH) / 2;
  localparam logic [PW-1:0] START_CODE = PW'(START + OFF);

  logic [PW-1:0] addr_n;
  logic [PW-1:0] code_n;

  always_comb begin
    addr_n = addr;
    if (adv) addr_n = (addr == PW'(DEPTH - 1)) ? '0 : addr + 1'b1;
    code_n = addr_n + PW'(OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= PW'(START);
      gray <= START_CODE ^ (START_CODE >> 1);
    end else begin
      addr <= addr_n;
      gray <= code_n ^ (code_n >> 1);
    end
  end
endmodule

// File: rtl/fsb_sync.sv
module fsb_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= INIT;
      q      <= INIT;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/fsb_ram.sv
module fsb_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 48,
  parameter int PW    = 6
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fsb_rd_ctrl.sv
module fsb_rd_ctrl
  import fsb_pkg::*;
#(
  parameter int DEPTH = 48,
  parameter int FRAME = 24,
  parameter int HALF  = 12,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] wr_gray_s,
  input  logic          pop,
  input  logic          align_s,
  output logic [PW-1:0] rd_addr,
  output logic          too_close,
  output logic          slip
);
  localparam int OFF = ((1 << PW) - DEPTH) / 2;

  // Adds k (1..DEPTH) to a and wraps the result into 0..DEPTH-1.
  function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] a, input int k);
    logic [PW:0] s;
    s = {1'b0, a} + (PW+1)'(k);
    if (s >= (PW+1)'(DEPTH)) s = s - (PW+1)'(DEPTH);
    return s[PW-1:0];
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wr_addr_s;
  logic [PW-1:0] sep;
  logic [PW-1:0] rd_n;
  logic          align_q;
  logic          align_rise;
  rd_step_e      step;

  always_comb begin
    wr_addr_s  = gray2bin(wr_gray_s) - PW'(OFF);
    sep        = wrap_add(wr_addr_s, DEPTH - int'(rd_addr));
    too_close  = (sep < PW'(HALF));
    align_rise = align_s & ~align_q;

    // A realign takes priority; the bytes around it are given up.
    if (align_rise && too_close)            step = RS_ALIGN;
    else if (pop && (sep == '0))            step = RS_REPEAT;
    else if (pop && (sep == PW'(DEPTH-1)))  step = RS_DROP;
    else if (pop)                           step = RS_NEXT;
    else                                    step = RS_HOLD;

    case (step)
      RS_NEXT:   rd_n = wrap_add(rd_addr, 1);
      RS_REPEAT: rd_n = wrap_add(rd_addr, DEPTH - FRAME);
      RS_DROP:   rd_n = wrap_add(rd_addr, FRAME + 1);
      RS_ALIGN:  rd_n = wrap_add(wr_addr_s, DEPTH - HALF);
      default:   rd_n = rd_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr <= '0;
      align_q <= 1'b0;
      slip    <= 1'b0;
    end else begin
      rd_addr <= rd_n;
      align_q <= align_s;
      slip    <= (step == RS_REPEAT) || (step == RS_DROP);
    end
  end
endmodule

// File: rtl/frame_slip_buffer.sv
module frame_slip_buffer #(
  parameter int DATA_W      = 8,
  parameter int FRAME_SLOTS = 24
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              align_req,
  output logic              too_close,
  output logic              slip
);
  localparam int DEPTH = 2 * FRAME_SLOTS;
  localparam int HALF  = FRAME_SLOTS / 2;
  localparam int PW    = $clog2(DEPTH);
  localparam int OFF   = ((1 << PW) - DEPTH) / 2;
  localparam logic [PW-1:0] RST_CODE = PW'(HALF + OFF);
  localparam logic [PW-1:0] RST_GRAY = RST_CODE ^ (RST_CODE >> 1);

  logic [PW-1:0] wr_addr;
  logic [PW-1:0] wr_gray;
  logic [PW-1:0] wr_gray_s;
  logic [PW-1:0] rd_addr;
  logic          align_s;
  logic          wr_live;
  logic          rd_live;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) wr_live <= 1'b0;
    else        wr_live <= 1'b1;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) rd_live <= 1'b0;
    else        rd_live <= 1'b1;
  end

  assign in_ready  = wr_live;
  assign out_valid = rd_live;

  fsb_wr_ptr #(.DEPTH(DEPTH), .START(HALF), .PW(PW)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .adv(in_valid && in_ready),
    .addr(wr_addr), .gray(wr_gray)
  );

  fsb_ram #(.DW(DATA_W), .DEPTH(DEPTH), .PW(PW)) u_ram (
    .wclk(wr_clk), .rst_n(rst_n), .we(in_valid && in_ready),
    .waddr(wr_addr), .wdata(in_data), .raddr(rd_addr), .rdata(out_data)
  );

  fsb_sync #(.W(PW), .INIT(RST_GRAY)) u_wsync (
    .clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s)
  );

  fsb_sync #(.W(1), .INIT(1'b0)) u_async (
    .clk(rd_clk), .rst_n(rst_n), .d(align_req), .q(align_s)
  );

  fsb_rd_ctrl #(.DEPTH(DEPTH), .FRAME(FRAME_SLOTS), .HALF(HALF), .PW(PW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .wr_gray_s(wr_gray_s),
    .pop(out_valid && out_ready), .align_s(align_s),
    .rd_addr(rd_addr), .too_close(too_close), .slip(slip)
  );
endmodule

// File: rtl/fsb_checker.sv
module fsb_checker #(
  parameter int DEPTH = 48,
  parameter int HALF  = 12,
  parameter int PW    = 6
) (
  input logic          rd_clk,
  input logic          rst_n,
  input logic          out_ready,
  input logic          out_valid,
  input logic          align_s,
  input logic          too_close,
  input logic          slip,
  input logic [PW-1:0] rd_addr,
  input logic [PW-1:0] wr_gray_s
);
  localparam int OFF = ((1 << PW) - DEPTH) / 2;

  logic [PW-1:0] wbin;
  logic [PW:0]   tgt;
  logic [PW-1:0] tgt_m;

  always_comb begin
    wbin[PW-1] = wr_gray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wr_gray_s[i];
    tgt   = {1'b0, wbin - PW'(OFF)} + (PW+1)'(DEPTH - HALF);
    tgt_m = (tgt >= (PW+1)'(DEPTH)) ? PW'(tgt - (PW+1)'(DEPTH)) : tgt[PW-1:0];
  end

  // R2
  hold_idx_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!out_ready && !$rose(align_s)) |=> $stable(rd_addr));

  // R4
  align_jump_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    ($rose(align_s) && too_close) |=> (rd_addr == $past(tgt_m)));

  // R5
  align_noop_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    ($rose(align_s) && !too_close && !out_ready) |=> $stable(rd_addr));

  // R6
  level_idle_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (align_s && $past(align_s) && !out_ready) |=> $stable(rd_addr));

  // R7
  slip_cause_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    slip |-> $past(out_ready));

  // R9
  out_live_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    out_valid |=> out_valid);

  // R10
  slip_pulse_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    slip |=> !slip);
endmodule

bind frame_slip_buffer fsb_checker #(.DEPTH(DEPTH), .HALF(HALF), .PW(PW)) u_chk (
  .rd_clk(rd_clk), .rst_n(rst_n), .out_ready(out_ready), .out_valid(out_valid),
  .align_s(align_s), .too_close(too_close), .slip(slip),
  .rd_addr(rd_addr), .wr_gray_s(wr_gray_s)
);

// File: tb/frame_slip_buffer_test.sv
module frame_slip_buffer_test;
  logic       wr_clk = 1'b0;
  logic       rd_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_ready = 1'b0;
  logic       align_req = 1'b0;
  logic       in_ready, out_valid, too_close, slip;
  logic [7:0] out_data;

  logic [7:0] q_exp[$];
  logic [7:0] hist[$];
  logic [7:0] next_val = 8'h01;
  bit         sb_on = 1'b1;
  int         n_cmp = 0;
  int         n_bad = 0;
  int         slip_cnt = 0;
  bit         done = 1'b0;

  frame_slip_buffer uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .align_req(align_req), .too_close(too_close), .slip(slip)
  );

  always #4 rd_clk = ~rd_clk;
  initial begin
    #3;
    forever #5 wr_clk = ~wr_clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Monitor: a byte is taken at the next rising edge when out_ready is high.
  always @(negedge rd_clk) begin
    if (slip) slip_cnt++;
    if (rst_n && out_ready && out_valid && sb_on) begin
      if (q_exp.size() == 0) check(1'b0, "R2 order", int'(out_data), -1);
      else begin
        logic [7:0] e;
        e = q_exp.pop_front();
        check(out_data == e, "R2 order", int'(out_data), int'(e));
      end
    end
  end

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge wr_clk); #2;
      in_valid = 1'b1;
      in_data  = next_val;
      q_exp.push_back(next_val);
      hist.push_back(next_val);
      next_val = next_val + 8'd1;
    end
    @(posedge wr_clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic read_n(input int n);
    @(posedge rd_clk); #2;
    out_ready = 1'b1;
    repeat (n) @(posedge rd_clk);
    #2;
    out_ready = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(posedge rd_clk);
    #2;
  endtask

  task automatic set_align(input logic v);
    @(posedge rd_clk); #2;
    align_req = v;
    settle();
  endtask

  task automatic rebuild(input int k);
    q_exp.delete();
    for (int i = hist.size() - k; i < hist.size(); i++) q_exp.push_back(hist[i]);
  endtask

  initial begin
    repeat (60000) @(posedge rd_clk);
    check(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    for (int i = 0; i < 12; i++) q_exp.push_back(8'h00);
    repeat (3) @(posedge rd_clk);
    #2 rst_n = 1'b1;
    settle();
    // R1: reset state
    check(too_close == 1'b0, "R1 too_close", int'(too_close), 0);
    check(slip_cnt == 0, "R1 slip", slip_cnt, 0);
    // R9: both stream sides live
    check(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);
    check(out_valid == 1'b1, "R9 out_valid", int'(out_valid), 1);

    // R2: concurrent streams, first 12 reads are the cleared store (R1)
    fork
      write_n(24);
      begin #40; read_n(24); end
    join
    settle();
    check(too_close == 1'b0, "R2 distance 12", int'(too_close), 0);
    check(q_exp.size() == 12, "R2 backlog", q_exp.size(), 12);

    // R3: distance 7 is below half a frame
    read_n(5);
    settle();
    check(too_close == 1'b1, "R3 close at 7", int'(too_close), 1);

    // R4: rising edge realigns to 12 behind the write index
    set_align(1'b1);
    check(too_close == 1'b0, "R4 realigned", int'(too_close), 0);
    rebuild(12);
    read_n(4);
    settle();

    // R6: level held high does not act again (distance 8, then 6)
    check(too_close == 1'b1, "R6 held level idle", int'(too_close), 1);
    read_n(2);
    settle();
    check(too_close == 1'b1, "R6 still close", int'(too_close), 1);
    check(q_exp.size() == 6, "R6 data undisturbed", q_exp.size(), 6);
    set_align(1'b0);
    set_align(1'b1);
    check(too_close == 1'b0, "R6 re-armed action", int'(too_close), 0);
    rebuild(12);
    read_n(12);
    settle();
    check(too_close == 1'b1, "R3 close at 0", int'(too_close), 1);
    check(slip_cnt == 0, "R7 no slip on draining to 0", slip_cnt, 0);

    // R7: read at distance 0 repeats a frame
    sb_on = 1'b0;
    read_n(1);
    settle();
    sb_on = 1'b1;
    check(slip_cnt == 1, "R7 slip pulse once (R10)", slip_cnt, 1);
    check(too_close == 1'b0, "R7 distance 24", int'(too_close), 0);
    rebuild(24);
    read_n(24);
    settle();
    check(q_exp.size() == 0, "R7 repeated frame read", q_exp.size(), 0);

    // R5: distance exactly 12, new rising edge has no effect
    write_n(12);
    settle();
    check(too_close == 1'b0, "R3 not close at 12", int'(too_close), 0);
    set_align(1'b0);
    set_align(1'b1);
    check(too_close == 1'b0, "R5 unchanged", int'(too_close), 0);
    check(q_exp.size() == 12, "R5 backlog kept", q_exp.size(), 12);
    read_n(12);
    settle();

    // R8: distance 47, a read drops the next frame
    write_n(47);
    settle();
    check(too_close == 1'b0, "R8 full not close", int'(too_close), 0);
    read_n(1);
    settle();
    check(slip_cnt == 2, "R8 slip pulse (R10)", slip_cnt, 2);
    for (int i = 0; i < 24; i++) void'(q_exp.pop_front());
    check(too_close == 1'b0, "R8 distance 22", int'(too_close), 0);
    read_n(22);
    settle();
    check(q_exp.size() == 0, "R8 tail delivered", q_exp.size(), 0);
    check(too_close == 1'b1, "R3 close after drain", int'(too_close), 1);
    check(slip_cnt == 2, "R10 no extra slips", slip_cnt, 2);
    report();
  end
endmodule